// File: doc/BRIEF.md
# Shift and Rotate-with-Mask Unit

This block is the shift datapath of an integer execution pipeline. For each issued operation it takes a 64-bit source, a shift count and an operation code. It returns a 64-bit result one clock edge later. The count comes either from a general register or from a small immediate field. The unit performs logical left and right shifts and arithmetic right shifts, on full 64-bit doublewords or on the low 32-bit word. It also performs a 32-bit rotate left whose output is ANDed with a contiguous or wrapping bit mask, set by a begin index and an end index.

Arithmetic right shifts update a carry flag that shows whether a negative source lost any one bits. When the record bit is set, a three-bit condition field records how the signed result compares with zero. The carry flag and the condition field hold their values until an operation updates them. Operations are decoded upstream. The unit sees only the operation code, the count source select, the mask indices and the record bit.

Top module: `shrot_unit`

## Requirements
- R1: Doubleword logical shifts (op_sel 0 = left, 1 = right) with a register count use cnt_reg[6:0]. Vacated bits fill with zeros, and any count from 64 to 127 yields a zero result.
- R2: Word logical shifts (op_sel 3 = left, 4 = right) with a register count operate on src[31:0] using cnt_reg[5:0]. Counts from 32 to 63 give zero, and result[63:32] is always zero.
- R3: Arithmetic right shifts fill vacated bits with the sign bit. Doubleword (op_sel 2) uses src[63], and a register count of 64 to 127 gives all sign bits. Word (op_sel 5) uses src[31], a count of 32 to 63 gives 32 sign bits in the low half, and result[63:32] is zero.
- R4: With imm_sel = 1 the count is taken from imm_cnt. Doubleword shifts use all six bits and never go out of range. Word shifts and the rotate use imm_cnt[4:0].
- R5: An arithmetic right shift sets carry to 1 exactly when the source (src[63] or src[31]) is negative and at least one 1 bit was shifted out. Otherwise it sets carry to 0.
- R6: Logical shifts, rotates and idle cycles leave carry unchanged.
- R7: The rotate (op_sel 6) rotates src[31:0] left by the low 5 count bits. It then ANDs the rotated word with a mask, and result[63:32] is zero. Word bit positions are numbered 0..31 from the most significant bit. When mask_begin <= mask_end, the mask has ones at positions mask_begin through mask_end, which are bits 31-mask_begin down to 31-mask_end.
- R8: With mask_begin = 0 and mask_end = 31, the rotate returns a plain 32-bit rotate left.
- R9: With mask_begin > mask_end, the mask wraps around. It has ones at positions mask_begin..31 and 0..mask_end.
- R10: When rec_en = 1, cond is set from a signed comparison of the 64-bit result with zero. The encoding is cond[2] = less, cond[1] = greater, cond[0] = equal. When rec_en = 0, cond holds its value.
- R11: Outputs are registered and change on the clock edge that samples op_valid = 1. Without op_valid they hold. Reset clears result, carry and cond to zero. An unassigned op_sel code (7) yields a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_sel | input | 3 | Operation code (0..6 as in the requirements) |
| src | input | 64 | Source value |
| cnt_reg | input | 64 | Register count source |
| imm_sel | input | 1 | 1 selects imm_cnt as the count |
| imm_cnt | input | 6 | Immediate count |
| mask_begin | input | 5 | Mask begin position for the rotate |
| mask_end | input | 5 | Mask end position for the rotate |
| rec_en | input | 1 | Record bit: update cond |
| result | output | 64 | Registered result |
| carry | output | 1 | Carry flag from arithmetic right shifts |
| cond | output | 3 | Less / greater / equal field |

## Verification
Every path through the unit ends in a register that the next operation does not mask. A wrong stage in the barrel, a mis-decoded count or a bad mask bit therefore shows on result at the edge right after the faulty operation is issued. A wrong shifted-out detector corrupts only carry. That error stays visible on the port until the next arithmetic shift, so a following logical shift is checked to make sure carry neither moved nor was lost. Condition-field faults show only after operations with rec_en set. Those operations are chosen to give negative, positive and zero results.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

   typedef enum logic [2:0] {
      OP_SHL_D = 3'd0,
      OP_SHR_D = 3'd1,
      OP_SAR_D = 3'd2,
      OP_SHL_W = 3'd3,
      OP_SHR_W = 3'd4,
      OP_SAR_W = 3'd5,
      OP_ROT_W = 3'd6
   } shrot_op_e;

   function automatic logic op_is_arith(input logic [2:0] op);
      return (op == OP_SAR_D) || (op == OP_SAR_W);
   endfunction

   function automatic logic op_is_word(input logic [2:0] op);
      return (op == OP_SHL_W) || (op == OP_SHR_W) || (op == OP_SAR_W) || (op == OP_ROT_W);
   endfunction

endpackage

// File: rtl/shrot_count_sel.sv
module shrot_count_sel
   import shrot_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int SH_W  = $clog2(DATA_W),
   localparam int HALF_W = DATA_W / 2
) (
   input  logic [2:0]      op_sel,
   input  logic [SH_W:0]   cnt_low,
   input  logic            imm_sel,
   input  logic [SH_W-1:0] imm_cnt,
   output logic [SH_W-1:0] amt,
   output logic            oor
);

   localparam logic [SH_W-1:0] HALF_AMT = SH_W'(HALF_W);

   logic [SH_W-2:0] n_small;
   logic            word_op;
   logic            rot_op;

   assign word_op = op_is_word(op_sel);
   assign rot_op  = (op_sel == OP_ROT_W);
   assign n_small = imm_sel ? imm_cnt[SH_W-2:0] : cnt_low[SH_W-2:0];

   always_comb begin
      oor = 1'b0;
      if (rot_op) begin
         // rotate left by n realised as right shift of {w,w} by HALF-n
         amt = HALF_AMT - {1'b0, n_small};
      end else if (word_op) begin
         amt = imm_sel ? {1'b0, imm_cnt[SH_W-2:0]} : cnt_low[SH_W-1:0];
      end else begin
         amt = imm_sel ? imm_cnt : cnt_low[SH_W-1:0];
         oor = !imm_sel && cnt_low[SH_W];
      end
   end

endmodule

// File: rtl/shrot_barrel.sv
module shrot_barrel #(
   parameter int DATA_W = 64,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SH_W-1:0]   amt,
   input  logic              fill,
   output logic [DATA_W-1:0] dout,
   output logic              lost
);

   logic [SH_W:0][DATA_W-1:0] stg;
   logic [SH_W:0]             lost_v;

   assign stg[0]    = din;
   assign lost_v[0] = 1'b0;

   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int SZ = 1 << s;
      assign stg[s+1]    = amt[s] ? {{SZ{fill}}, stg[s][DATA_W-1:SZ]} : stg[s];
      assign lost_v[s+1] = lost_v[s] | (amt[s] & (|stg[s][SZ-1:0]));
   end

   assign dout = stg[SH_W];
   assign lost = lost_v[SH_W];

   // R5: an unshifted value never reports lost bits
   always_comb begin
      if (amt == '0) begin
         a_r5_no_loss_at_zero: assert (!lost);
      end
   end

endmodule

// File: rtl/shrot_mask.sv
module shrot_mask #(
   parameter int HALF_W = 32,
   localparam int MB_W  = $clog2(HALF_W)
) (
   input  logic [MB_W-1:0]   mb,
   input  logic [MB_W-1:0]   me,
   output logic [HALF_W-1:0] mask
);

   logic wrap;
   assign wrap = (mb > me);

   for (genvar k = 0; k < HALF_W; k++) begin : g_pos
      localparam logic [MB_W-1:0] K = MB_W'(k);
      // position k counts from the word's most significant bit
      assign mask[HALF_W-1-k] = wrap ? ((K >= mb) || (K <= me))
                                     : ((K >= mb) && (K <= me));
   end

   always_comb begin
      if (mb == '0 && me == MB_W'(HALF_W-1)) begin
         a_r8_full_mask: assert (&mask);
      end
      if (mb == me) begin
         a_r7_single_bit: assert ($countones(mask) == 1);
      end
   end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int SH_W   = $clog2(DATA_W),
   localparam int HALF_W = DATA_W / 2,
   localparam int MB_W   = $clog2(HALF_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_sel,
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] cnt_reg,
   input  logic              imm_sel,
   input  logic [SH_W-1:0]   imm_cnt,
   input  logic [MB_W-1:0]   mask_begin,
   input  logic [MB_W-1:0]   mask_end,
   input  logic              rec_en,
   output logic [DATA_W-1:0] result,
   output logic              carry,
   output logic [2:0]        cond
);

   if (DATA_W < 16 || (1 << SH_W) != DATA_W) begin : g_bad_width
      $error("shrot_unit: DATA_W must be a power of two of at least 16");
   end

   logic [HALF_W-1:0] lo;
   logic [DATA_W-1:0] lo_zx, lo_sx, src_rev, lo_rev, b_in, b_out, b_out_rev, b_fix;
   logic [DATA_W-1:0] res_n;
   logic [HALF_W-1:0] mask;
   logic [SH_W-1:0]   amt;
   logic              oor, fill, left, word, rot, arith, legal, b_lost, carry_n;
   logic              unused_cnt_hi;

   assign lo            = src[HALF_W-1:0];
   assign lo_zx         = {{HALF_W{1'b0}}, lo};
   assign lo_sx         = {{HALF_W{lo[HALF_W-1]}}, lo};
   assign unused_cnt_hi = ^cnt_reg[DATA_W-1:SH_W+1];

   for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign src_rev[i]   = src[DATA_W-1-i];
      assign lo_rev[i]    = lo_zx[DATA_W-1-i];
      assign b_out_rev[i] = b_out[DATA_W-1-i];
   end

   shrot_count_sel #(.DATA_W(DATA_W)) i_cnt (
      .op_sel  (op_sel),
      .cnt_low (cnt_reg[SH_W:0]),
      .imm_sel (imm_sel),
      .imm_cnt (imm_cnt),
      .amt     (amt),
      .oor     (oor)
   );

   shrot_mask #(.HALF_W(HALF_W)) i_mask (
      .mb   (mask_begin),
      .me   (mask_end),
      .mask (mask)
   );

   always_comb begin
      b_in  = '0;
      fill  = 1'b0;
      left  = 1'b0;
      word  = 1'b0;
      rot   = 1'b0;
      arith = 1'b0;
      legal = 1'b1;
      case (shrot_op_e'(op_sel))
         OP_SHL_D: begin b_in = src_rev; left = 1'b1; end
         OP_SHR_D: begin b_in = src; end
         OP_SAR_D: begin b_in = src; fill = src[DATA_W-1]; arith = 1'b1; end
         OP_SHL_W: begin b_in = lo_rev; left = 1'b1; word = 1'b1; end
         OP_SHR_W: begin b_in = lo_zx; word = 1'b1; end
         OP_SAR_W: begin b_in = lo_sx; fill = lo[HALF_W-1]; arith = 1'b1; word = 1'b1; end
         OP_ROT_W: begin b_in = {lo, lo}; rot = 1'b1; end
         default:  legal = 1'b0;
      endcase
   end

   shrot_barrel #(.DATA_W(DATA_W)) i_barrel (
      .din  (b_in),
      .amt  (amt),
      .fill (fill),
      .dout (b_out),
      .lost (b_lost)
   );

   assign b_fix = left ? b_out_rev : b_out;

   always_comb begin
      if (!legal)
         res_n = '0;
      else if (rot)
         res_n = {{HALF_W{1'b0}}, b_out[HALF_W-1:0] & mask};
      else if (oor)
         res_n = {DATA_W{fill}};
      else if (word)
         res_n = {{HALF_W{1'b0}}, b_fix[HALF_W-1:0]};
      else
         res_n = b_fix;
   end

   assign carry_n = fill & (oor ? (|b_in) : b_lost);

   logic       vld_q;
   logic [2:0] op_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
         carry  <= 1'b0;
         cond   <= 3'b000;
         vld_q  <= 1'b0;
         op_q   <= 3'd0;
      end else begin
         vld_q <= op_valid;
         if (op_valid) begin
            result <= res_n;
            op_q   <= op_sel;
            if (arith)
               carry <= carry_n;
            if (rec_en)
               cond <= {res_n[DATA_W-1], !res_n[DATA_W-1] && (res_n != '0), res_n == '0};
         end
      end
   end

   a_r6_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !op_is_arith(op_q)) |-> $stable(carry));

   a_r2_word_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && op_is_word(op_q)) |-> (result[DATA_W-1:HALF_W] == '0));

   a_r1_dword_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $past(op_valid && (op_sel == OP_SHL_D || op_sel == OP_SHR_D) && !imm_sel && cnt_reg[SH_W])
      |-> (result == '0));

   a_r10_cond_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cond));

   a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_q |-> $stable(result));

endmodule

// File: tb/test_shrot_unit.sv
module test_shrot_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_sel = '0;
   logic [63:0] src = '0;
   logic [63:0] cnt_reg = '0;
   logic        imm_sel = 1'b0;
   logic [5:0]  imm_cnt = '0;
   logic [4:0]  mask_begin = '0;
   logic [4:0]  mask_end = '0;
   logic        rec_en = 1'b0;
   logic [63:0] result;
   logic        carry;
   logic [2:0]  cond;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;
   logic        exp_carry = 1'b0;
   logic [2:0]  exp_cond = 3'b000;
   logic [63:0] exp_res = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shrot_unit i_shrot_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel), .src(src),
      .cnt_reg(cnt_reg), .imm_sel(imm_sel), .imm_cnt(imm_cnt), .mask_begin(mask_begin),
      .mask_end(mask_end), .rec_en(rec_en), .result(result), .carry(carry), .cond(cond)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] m_mask(input logic [4:0] b, input logic [4:0] e);
      logic [31:0] m = '0;
      for (int k = 0; k < 32; k++) begin
         if (b <= e) m[31-k] = (k >= b) && (k <= e);
         else        m[31-k] = (k >= b) || (k <= e);
      end
      return m;
   endfunction

   // independent reference, returns {carry_valid, carry, result}
   function automatic logic [65:0] model(input logic [2:0] op, input logic [63:0] s,
         input logic [63:0] c, input logic is, input logic [5:0] im,
         input logic [4:0] b, input logic [4:0] e);
      int n;
      logic [31:0] w, r32;
      logic [63:0] r;
      logic cy, cv;
      w = s[31:0]; r = '0; cy = 1'b0; cv = 1'b0;
      case (op)
         3'd0, 3'd1, 3'd2: begin
            n = is ? int'(im) : int'(c[6:0]);
            if (op == 3'd0)      r = (n > 63) ? 64'd0 : s << n;
            else if (op == 3'd1) r = (n > 63) ? 64'd0 : s >> n;
            else begin
               cv = 1'b1;
               r = (n > 63) ? {64{s[63]}} : 64'($signed(s) >>> n);
               cy = s[63] && ((n > 63) ? (s != 0) : ((s & ((64'd1 << n) - 64'd1)) != 0));
            end
         end
         3'd3, 3'd4, 3'd5: begin
            n = is ? int'(im[4:0]) : int'(c[5:0]);
            if (op == 3'd3)      r32 = (n > 31) ? 32'd0 : w << n;
            else if (op == 3'd4) r32 = (n > 31) ? 32'd0 : w >> n;
            else begin
               cv = 1'b1;
               r32 = (n > 31) ? {32{w[31]}} : 32'($signed(w) >>> n);
               cy = w[31] && ((n > 31) ? 1'b1 : ((w & ((32'd1 << n) - 32'd1)) != 0));
            end
            r = {32'd0, r32};
         end
         3'd6: begin
            n = is ? int'(im[4:0]) : int'(c[4:0]);
            r32 = (n == 0) ? w : ((w << n) | (w >> (32 - n)));
            r = {32'd0, r32 & m_mask(b, e)};
         end
         default: r = '0;
      endcase
      return {cv, cy, r};
   endfunction

   task automatic apply(input string req, input logic [2:0] op, input logic [63:0] s,
         input logic [63:0] c, input logic is, input logic [5:0] im,
         input logic [4:0] b, input logic [4:0] e, input logic rc);
      logic [65:0] m;
      @(negedge clk);
      op_sel = op; src = s; cnt_reg = c; imm_sel = is; imm_cnt = im;
      mask_begin = b; mask_end = e; rec_en = rc; op_valid = 1'b1;
      m = model(op, s, c, is, im, b, e);
      exp_res = m[63:0];
      if (m[65]) exp_carry = m[64];
      if (rc) exp_cond = {exp_res[63], !exp_res[63] && exp_res != 0, exp_res == 0};
      @(negedge clk);
      op_valid = 1'b0;
      chk({req, " result"}, result, exp_res);
      chk({req, " carry"}, {63'd0, carry}, {63'd0, exp_carry});
      chk({req, " cond"}, {61'd0, cond}, {61'd0, exp_cond});
   endtask

   task automatic t_reset;
      chk("R11 reset result", result, 64'd0);
      chk("R11 reset carry", {63'd0, carry}, 64'd0);
      chk("R11 reset cond", {61'd0, cond}, 64'd0);
   endtask

   task automatic t_dword_logical;
      apply("R1 shl", 3'd0, 64'h8000_0000_0000_00F1, 64'd4, 0, 0, 0, 0, 0);
      apply("R1 shr", 3'd1, 64'hF000_0000_0000_00F1, 64'd63, 0, 0, 0, 0, 0);
      apply("R1 shr high garbage", 3'd1, 64'hDEAD_BEEF_0123_4567, 64'hFF00_0000_0000_0008, 0, 0, 0, 0, 0);
      apply("R1 shl oor 64", 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64, 0, 0, 0, 0, 0);
      apply("R1 shr oor 127", 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd127, 0, 0, 0, 0, 0);
      apply("R1 shl zero", 3'd0, 64'h1234_5678_9ABC_DEF0, 64'd128, 0, 0, 0, 0, 0);
   endtask

   task automatic t_word_logical;
      apply("R2 shl w", 3'd3, 64'hFFFF_FFFF_8000_00F1, 64'd4, 0, 0, 0, 0, 0);
      apply("R2 shr w", 3'd4, 64'hFFFF_FFFF_8000_0000, 64'd31, 0, 0, 0, 0, 0);
      apply("R2 shl w oor 32", 3'd3, 64'h0000_0000_FFFF_FFFF, 64'd32, 0, 0, 0, 0, 0);
      apply("R2 shr w oor 63", 3'd4, 64'h0000_0000_FFFF_FFFF, 64'd63, 0, 0, 0, 0, 0);
   endtask

   task automatic t_arith;
      apply("R3 R5 sar d neg lost", 3'd2, 64'h8000_0000_0000_0003, 64'd1, 0, 0, 0, 0, 0);
      apply("R3 R5 sar d neg clean", 3'd2, 64'h8000_0000_0000_0010, 64'd4, 0, 0, 0, 0, 0);
      apply("R3 R5 sar d pos lost", 3'd2, 64'h4000_0000_0000_00FF, 64'd8, 0, 0, 0, 0, 0);
      apply("R3 R5 sar d oor neg", 3'd2, 64'hFFFF_0000_0000_0000, 64'd100, 0, 0, 0, 0, 0);
      apply("R3 R5 sar w neg", 3'd5, 64'h0000_0000_8000_0001, 64'd4, 0, 0, 0, 0, 0);
      apply("R3 R5 sar w oor neg", 3'd5, 64'h1234_5678_8000_0000, 64'd40, 0, 0, 0, 0, 0);
      apply("R3 R5 sar w pos", 3'd5, 64'hFFFF_FFFF_7FFF_FFFF, 64'd16, 0, 0, 0, 0, 0);
   endtask

   task automatic t_imm;
      apply("R4 imm shl d 63", 3'd0, 64'd1, 64'd2, 1, 6'd63, 0, 0, 0);
      apply("R4 imm sar d", 3'd2, 64'h8000_0000_0000_0001, 64'd0, 1, 6'd60, 0, 0, 0);
      apply("R4 imm shr w 5bit", 3'd4, 64'h0000_0000_F000_0000, 64'd0, 1, 6'd36, 0, 0, 0);
      apply("R4 imm sar w", 3'd5, 64'h0000_0000_8000_0000, 64'd0, 1, 6'd31, 0, 0, 0);
   endtask

   task automatic t_carry_hold;
      apply("R5 set carry", 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 0, 0, 0, 0, 0);
      apply("R6 shl keeps carry", 3'd0, 64'd0, 64'd1, 0, 0, 0, 0, 0);
      apply("R6 rot keeps carry", 3'd6, 64'd5, 64'd1, 0, 0, 5'd0, 5'd31, 0);
      repeat (3) @(negedge clk);
      chk("R6 R11 idle keeps carry", {63'd0, carry}, {63'd0, exp_carry});
      chk("R11 idle keeps result", result, exp_res);
      apply("R5 clear carry", 3'd2, 64'h0000_0000_0000_00FF, 64'd4, 0, 0, 0, 0, 0);
      apply("R6 shr w keeps zero", 3'd4, 64'hFFFF_FFFF, 64'd4, 0, 0, 0, 0, 0);
   endtask

   task automatic t_rotate;
      apply("R8 plain rot 8", 3'd6, 64'hAAAA_AAAA_1234_5678, 64'd8, 0, 0, 5'd0, 5'd31, 0);
      apply("R8 plain rot 0", 3'd6, 64'h0000_0000_8765_4321, 64'd32, 0, 0, 5'd0, 5'd31, 0);
      apply("R7 field", 3'd6, 64'h0000_0000_1234_5678, 64'd4, 0, 0, 5'd8, 5'd15, 0);
      apply("R7 single bit", 3'd6, 64'h0000_0000_FFFF_FFFF, 64'd13, 0, 0, 5'd31, 5'd31, 0);
      apply("R9 wrap", 3'd6, 64'h0000_0000_DEAD_BEEF, 64'd12, 0, 0, 5'd28, 5'd3, 0);
      apply("R9 wrap full", 3'd6, 64'h0000_0000_0F0F_00FF, 64'd0, 1, 6'd7, 5'd16, 5'd15, 0);
      apply("R11 illegal op", 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 0);
   endtask

   task automatic t_record;
      apply("R10 negative", 3'd2, 64'h8000_0000_0000_0000, 64'd2, 0, 0, 0, 0, 1);
      apply("R10 held", 3'd1, 64'd0, 64'd1, 0, 0, 0, 0, 0);
      apply("R10 zero", 3'd1, 64'd1, 64'd1, 0, 0, 0, 0, 1);
      apply("R10 positive", 3'd0, 64'd1, 64'd62, 0, 0, 0, 0, 1);
      apply("R10 word positive", 3'd5, 64'h8000_0000, 64'd0, 0, 0, 0, 0, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_dword_logical();
      t_word_logical();
      t_arith();
      t_imm();
      t_carry_hold();
      t_rotate();
      t_record();
      done = 1;
   end

   initial begin
      for (int cyc = 0; cyc < 20000 && !done; cyc++) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule